// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Register Bank

This block holds one software-interrupt pending bit per hart behind a small memory-mapped window. Any hart can raise an inter-processor interrupt at another hart by writing a word whose bit 0 is 1 into that hart's slot. It withdraws the interrupt by writing a word whose bit 0 is 0. Each pending bit drives its hart's software-interrupt line directly as a level. Priority, delegation and any clearing from the core's own control registers happen outside this block.

Accesses arrive on a simple 32-bit register bus. Each request is answered exactly one cycle later with read data and a fault flag. An elaboration-time mode selects one of two read behaviours. In the machine-level flavour the pending bit can be read back. In the supervisor-level flavour the slots are write-only and always read as zero. The number of harts, the address width and the window size are parameters.

Top module: `swi_bank`

## Requirements
- R1: While reset is asserted and after it is released, every pending bit and every `sw_irq` output is 0, and `rsp_valid` is 0 until a request is accepted.
- R2: A write to a byte offset below 0x4000 whose slot number (offset divided by 4, rounded down) names an existing hart stores bit 0 of `req_wdata` as that hart's pending bit. Bits 31:1 are discarded, and the pending bits of all other harts are left unchanged.
- R3: `sw_irq[h]` equals hart h's pending bit. After a write is accepted at a clock edge, the new level is visible from that edge on. `sw_irq` does not change in any cycle without an accepted write.
- R4: With `MODE` = machine, a read of an existing hart's slot returns the pending bit in `rsp_rdata[0]` and 0 in bits 31:1. The value returned is the one stored before the read was accepted.
- R5: With `MODE` = supervisor, every read below offset 0x4000 returns 0 in all 32 bits, whatever the stored bits are.
- R6: A read or write at a byte offset of 0x4000 or above responds with `rsp_fault` = 1 and `rsp_rdata` = 0, and changes no pending bit.
- R7: A slot below 0x4000 whose slot number is not less than `NUM_HARTS` reads as 0, ignores writes and responds with `rsp_fault` = 0.
- R8: Every request accepted with `req_valid` = 1 yields `rsp_valid` = 1 in exactly the next cycle. A cycle without a request yields `rsp_valid` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_fault | output | 1 | The previous request was outside the window |
| rsp_rdata | output | 32 | Read data of the previous request |
| sw_irq | output | NUM_HARTS | Software-interrupt level per hart |

## Verification
A corrupted pending bit appears on `sw_irq` right away, with no delay. In the machine flavour it also appears on the next read of that slot, one cycle after the request. A wrong slot decode shows up in the cycle after the write, because the bench compares every hart's line there: one hart's line changes unexpectedly, or the targeted line stays unchanged. A fault or response-timing error is visible on `rsp_fault` or `rsp_valid` in the cycle after the request. Running the machine and supervisor instances side by side exposes any leak of stored state into supervisor read data.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic {
    SWI_MACHINE    = 1'b0,
    SWI_SUPERVISOR = 1'b1
  } swi_mode_e;

  localparam int unsigned SWI_DATA_W     = 32;
  localparam int unsigned SWI_WORD_BYTES = 4;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int unsigned NUM_HARTS    = 8,
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned WINDOW_BYTES = 16384,
  localparam int unsigned WIN_AW      = $clog2(WINDOW_BYTES),
  localparam int unsigned SLOT_W      = WIN_AW - $clog2(swi_pkg::SWI_WORD_BYTES),
  localparam int unsigned IDX_W       = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic              hart_hit,
  output logic [IDX_W-1:0]  hart_idx
);
  localparam int unsigned LSB = $clog2(swi_pkg::SWI_WORD_BYTES);

  logic [SLOT_W-1:0] slot;
  logic [LSB-1:0]    unused_byte_lane;

  assign slot             = addr[WIN_AW-1:LSB];
  assign unused_byte_lane = addr[LSB-1:0];

  generate
    if (ADDR_W > WIN_AW) begin : g_range
      assign in_window = ~|addr[ADDR_W-1:WIN_AW];
    end else begin : g_full
      assign in_window = 1'b1;
    end
  endgenerate

  assign hart_hit = in_window && (32'(slot) < 32'(NUM_HARTS));
  assign hart_idx = slot[IDX_W-1:0];
endmodule

// File: rtl/swi_pending_bank.sv
module swi_pending_bank #(
  parameter int unsigned NUM_HARTS = 8,
  localparam int unsigned IDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_bit,
  output logic [NUM_HARTS-1:0] pend
);
  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      always_ff @(posedge clk) begin
        if (rst) begin
          pend[h] <= 1'b0;
        end else if (wr_en && (32'(wr_idx) == h)) begin
          pend[h] <= wr_bit;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/swi_response.sv
module swi_response #(
  parameter int unsigned        NUM_HARTS = 8,
  parameter swi_pkg::swi_mode_e MODE      = swi_pkg::SWI_MACHINE,
  localparam int unsigned       IDX_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int unsigned       DW        = swi_pkg::SWI_DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 in_window,
  input  logic                 hart_hit,
  input  logic [IDX_W-1:0]     hart_idx,
  input  logic [NUM_HARTS-1:0] pend,
  output logic                 rsp_valid,
  output logic                 rsp_fault,
  output logic [DW-1:0]        rsp_rdata
);
  logic rd_bit;

  generate
    if (MODE == swi_pkg::SWI_MACHINE) begin : g_readable
      assign rd_bit = hart_hit && !req_write && pend[hart_idx];
    end else begin : g_write_only
      logic unused_state;
      assign unused_state = ^{pend, hart_idx, hart_hit};
      assign rd_bit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && !in_window;
      rsp_rdata <= {{(DW-1){1'b0}}, req_valid && rd_bit};
    end
  end
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int unsigned        NUM_HARTS    = 8,
  parameter int unsigned        ADDR_W       = 16,
  parameter int unsigned        WINDOW_BYTES = 16384,
  parameter swi_pkg::swi_mode_e MODE         = swi_pkg::SWI_MACHINE
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_fault,
  output logic [31:0]            rsp_rdata,
  output logic [NUM_HARTS-1:0]   sw_irq
);
  localparam int unsigned IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic             in_window;
  logic             hart_hit;
  logic [IDX_W-1:0] hart_idx;
  logic             wr_en;
  logic [30:0]      unused_wdata;

  assign unused_wdata = req_wdata[31:1];
  assign wr_en        = req_valid && req_write && hart_hit;

  swi_decode #(
    .NUM_HARTS   (NUM_HARTS),
    .ADDR_W      (ADDR_W),
    .WINDOW_BYTES(WINDOW_BYTES)
  ) u_decode (
    .addr     (req_addr),
    .in_window(in_window),
    .hart_hit (hart_hit),
    .hart_idx (hart_idx)
  );

  swi_pending_bank #(
    .NUM_HARTS(NUM_HARTS)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wr_idx(hart_idx),
    .wr_bit(req_wdata[0]),
    .pend  (sw_irq)
  );

  swi_response #(
    .NUM_HARTS(NUM_HARTS),
    .MODE     (MODE)
  ) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .in_window(in_window),
    .hart_hit (hart_hit),
    .hart_idx (hart_idx),
    .pend     (sw_irq),
    .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk #(
  parameter int unsigned        NUM_HARTS    = 8,
  parameter int unsigned        ADDR_W       = 16,
  parameter int unsigned        WINDOW_BYTES = 16384,
  parameter swi_pkg::swi_mode_e MODE         = swi_pkg::SWI_MACHINE
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [31:0]          req_wdata,
  input logic                 rsp_valid,
  input logic                 rsp_fault,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_HARTS-1:0] sw_irq
);
  localparam logic [31:0] LIMIT = 32'(WINDOW_BYTES);

  logic        ck_in_win;
  logic        ck_wr_hit;
  logic [31:0] ck_slot;
  logic [30:0] unused_ck;

  assign unused_ck = req_wdata[31:1];
  assign ck_in_win = 32'(req_addr) < LIMIT;
  assign ck_slot   = 32'(req_addr) >> 2;
  assign ck_wr_hit = req_valid && req_write && ck_in_win && (ck_slot < 32'(NUM_HARTS));

  AST_IRQ_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sw_irq == '0 && !rsp_valid)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ck_wr_hit |=> sw_irq[$past(ck_slot)] == $past(req_wdata[0])); // R2

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ck_wr_hit |=> $stable(sw_irq)); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rdata[31:1] == '0); // R4

  AST_SUP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (MODE == swi_pkg::SWI_SUPERVISOR && rsp_valid) |-> rsp_rdata == '0); // R5

  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_fault == !$past(ck_in_win)); // R6

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R8

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R8
endmodule

bind swi_bank swi_bank_chk #(
  .NUM_HARTS   (NUM_HARTS),
  .ADDR_W      (ADDR_W),
  .WINDOW_BYTES(WINDOW_BYTES),
  .MODE        (MODE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault),
  .rsp_rdata(rsp_rdata),
  .sw_irq   (sw_irq)
);

// File: tb/swi_bank_test.sv
module swi_bank_test;
  localparam int N  = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [31:0]   req_wdata = '0;
  logic          m_valid, m_fault, s_valid, s_fault;
  logic [31:0]   m_rdata, s_rdata;
  logic [N-1:0]  m_irq, s_irq;

  logic [N-1:0]  model = '0;
  int            checks = 0;
  int            fails = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(swi_pkg::SWI_MACHINE)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(m_valid),
    .rsp_fault(m_fault), .rsp_rdata(m_rdata), .sw_irq(m_irq));

  swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(swi_pkg::SWI_SUPERVISOR)) uut_sup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(s_valid),
    .rsp_fault(s_fault), .rsp_rdata(s_rdata), .sw_irq(s_irq));

  function automatic bit in_win(logic [AW-1:0] a);
    return 32'(a) < 32'h4000;
  endfunction

  function automatic bit hits_hart(logic [AW-1:0] a);
    return in_win(a) && ((32'(a) >> 2) < N);
  endfunction

  function automatic logic [31:0] exp_mread(logic [AW-1:0] a, logic [N-1:0] m);
    if (!hits_hart(a)) return 32'h0;
    return {31'h0, m[32'(a) >> 2]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [AW-1:0] a, logic [31:0] d);
    logic [31:0] em;
    logic [N-1:0] nm;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    em = wr ? 32'h0 : exp_mread(a, model);
    nm = model;
    if (wr && hits_hart(a)) nm[32'(a) >> 2] = d[0];
    @(negedge clk);
    check(m_valid && s_valid, "R8", "rsp_valid", {30'h0, m_valid, s_valid}, 32'h3);
    check(m_fault == !in_win(a) && s_fault == !in_win(a), in_win(a) ? "R7" : "R6",
          "rsp_fault", {30'h0, m_fault, s_fault}, {30'h0, !in_win(a), !in_win(a)});
    check(m_rdata == em, in_win(a) ? (hits_hart(a) ? "R4" : "R7") : "R6",
          "machine rdata", m_rdata, em);
    check(s_rdata == 32'h0, "R5", "supervisor rdata", s_rdata, 32'h0);
    check(m_irq == nm && s_irq == nm, wr ? "R2" : "R3", "sw_irq", 32'(m_irq), 32'(nm));
    model = nm;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5A5A));
    repeat (3) @(negedge clk);
    check(m_irq == '0 && !m_valid, "R1", "in reset", {m_valid, 31'(m_irq)}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(m_irq == '0 && s_irq == '0 && !m_valid && !s_valid, "R1", "after reset",
          {m_valid, 31'(m_irq)}, 32'h0);

    access(1'b1, 16'h0000, 32'hFFFF_FFFE);          // R2 bit 0 only
    access(1'b1, 16'h000C, 32'h0000_0001);          // R2 R3 hart 3
    access(1'b0, 16'h000C, 32'h0);                  // R4 read back 1
    access(1'b0, 16'h000E, 32'h0);                  // R4 unaligned byte lane
    access(1'b1, 16'h001C, 32'h8000_0003);          // R2 last hart
    access(1'b1, 16'h0020, 32'h1);                  // R7 first missing hart
    access(1'b0, 16'h0020, 32'h0);                  // R7
    access(1'b1, 16'h3FFC, 32'h1);                  // R7 top of window
    access(1'b1, 16'h4000, 32'h1);                  // R6 first fault
    access(1'b0, 16'h4000, 32'h0);                  // R6
    access(1'b1, 16'hFFFC, 32'hFFFF_FFFF);          // R6
    access(1'b1, 16'h000C, 32'h0);                  // R3 clear hart 3
    @(negedge clk);
    check(!m_valid && !s_valid, "R8", "idle rsp_valid", {31'h0, m_valid}, 32'h0);

    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [AW-1:0] a;
      sel = int'($urandom_range(0, 99));
      if (sel < 70)      a = AW'(($urandom_range(0, N-1) << 2) | $urandom_range(0, 3));
      else if (sel < 85) a = AW'($urandom_range(N*4, 32'h3FFF));
      else               a = AW'($urandom_range(32'h4000, 32'hFFFF));
      access($urandom_range(0, 1) == 1, a, $urandom);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule